// File: doc/BRIEF.md
# SD Write Status Token Receiver

After a host has pushed one 4-bit data block and its end nibble to an SD card, the card answers on data line 0. It sends a short status token: a low start bit, three outcome bits and a high end bit. It then holds the line low for as long as it is busy programming the block. This receiver watches that line and finds the token wherever it begins in the idle-high stream. It decodes the outcome into one of four status codes. It only signals completion once the card has released the line, so the sequencer above it can go straight on to the next block or abort the transfer.

The line is sampled only on cycles where the SD clock enable is high. A single-cycle arm strobe, issued after the end nibble, starts a new search. A programmable cycle limit bounds the whole operation: the token search and the busy wait together. The limit is meant to be set to roughly one second of system clock. There is also a fixed limit on how many idle-high samples may pass before the start bit is given up on.

Top module: `sdWrStatusRx`

## Requirements
- R1: After reset, `ready` is 1, `done`, `abortXfer` and `timedOut` are 0, and `status` is 3 (unknown).
- R2: After an `arm` cycle, only cycles with `sdClkEn` high sample `dat0`. High samples before the token are skipped, and the first low sample is taken as the start bit.
- R3: The three samples after the start bit form the outcome code, first sample in the most significant bit. Code 3'b010 gives `status` 0 (accepted), and `abortXfer` stays 0.
- R4: Code 3'b101 gives `status` 1 (CRC error seen by the card), and `abortXfer` pulses together with `done`.
- R5: Code 3'b110 gives `status` 2 (write failure), and `abortXfer` pulses together with `done`.
- R6: Any other code gives `status` 3 (unknown failure), and `abortXfer` pulses together with `done`.
- R7: The sample after the code is the end bit, and its value is ignored. After it, low samples mean the card is busy. `done` is a one-cycle pulse that goes high in the cycle after the edge that takes the first high sample after the end bit. `ready` is 1 from that same cycle on.
- R8: If WIN_BITS high samples arrive after `arm` without a start bit, the search ends: `done` pulses with `status` 3 and `abortXfer`.
- R9: If no completion has happened by the (timeoutLimit+1)-th clock edge after the arming edge, `done` pulses after that edge with `status` 3, `abortXfer` and `timedOut`. `timedOut` stays 1 until the next `arm`. A completion by sample on that same edge takes precedence.
- R10: `arm` while a search or busy wait is in progress restarts the search from the beginning and clears `timedOut`.
- R11: While `ready` is 1 and `arm` is low, samples on `dat0` have no effect: no `done`, and `status` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| arm | input | 1 | Start a new token search (one cycle) |
| sdClkEn | input | 1 | Sample strobe for `dat0`, one per SD clock |
| dat0 | input | 1 | Data line 0 level |
| timeoutLimit | input | TMO_W | Cycle limit for search plus busy wait |
| ready | output | 1 | No search or busy wait in progress |
| done | output | 1 | One-cycle completion pulse |
| status | output | 2 | 0 accepted, 1 CRC error, 2 write failure, 3 unknown |
| abortXfer | output | 1 | Pulses with `done` when status is not accepted |
| timedOut | output | 1 | Last operation ended by the cycle limit |

## Verification
The bench builds the block with WIN_BITS = 12 and TMO_W = 10. With these values, running out of the search window takes only a dozen samples. Timeouts of a few tens of cycles can be programmed, so a silent line and a card that stays busy forever can both be reached in a short run. A large limit is used for the ordinary token cases. The sample strobe is run both every cycle and with gaps, to show that only strobed cycles count. A reference model in the bench, built on integers, follows every clock edge. It covers restarts in mid-token and timeouts that land next to a sample.

// File: rtl/sdWrStatusPkg.sv
package sdWrStatusPkg;

  localparam int CODE_BITS = 3;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_CODE,
    ST_ENDB,
    ST_BUSY
  } rxState_e;

  typedef enum logic [1:0] {
    WS_ACCEPT  = 2'd0,
    WS_CRCERR  = 2'd1,
    WS_WRFAIL  = 2'd2,
    WS_UNKNOWN = 2'd3
  } wrStatus_e;

  // strobes from control to datapath
  typedef struct packed {
    logic armClr;
    logic shiftCode;
    logic finDecode;
    logic finUnknown;
    logic finTimeout;
  } dpCtrl_t;

  function automatic wrStatus_e decodeOutcome(input logic [CODE_BITS-1:0] code);
    case (code)
      3'b010:  return WS_ACCEPT;
      3'b101:  return WS_CRCERR;
      3'b110:  return WS_WRFAIL;
      default: return WS_UNKNOWN;
    endcase
  endfunction

endpackage

// File: rtl/sdWrStatusCtl.sv
module sdWrStatusCtl
  import sdWrStatusPkg::*;
#(
  parameter int WIN_BITS = 32,
  parameter int TMO_W    = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             sdClkEn,
  input  logic             dat0,
  input  logic [TMO_W-1:0] timeoutLimit,
  output dpCtrl_t          ctrl,
  output logic             ready
);

  localparam int WIN_W = (WIN_BITS > 1) ? $clog2(WIN_BITS) : 1;
  localparam int BIT_W = $clog2(CODE_BITS);
  localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_BITS - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(CODE_BITS - 1);

  rxState_e         state, stNext;
  logic [WIN_W-1:0] winCnt, winNext;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic [TMO_W-1:0] tmoCnt;
  logic             tmoHit;

  assign ready  = (state == ST_IDLE);
  assign tmoHit = (state != ST_IDLE) && (tmoCnt == timeoutLimit);

  always_comb begin
    ctrl    = '0;
    stNext  = state;
    winNext = winCnt;
    bitNext = bitCnt;
    if (arm) begin
      ctrl.armClr = 1'b1;
      stNext      = ST_HUNT;
      winNext     = '0;
      bitNext     = '0;
    end else begin
      if (sdClkEn) begin
        case (state)
          ST_HUNT: begin
            if (!dat0) begin
              stNext  = ST_CODE;
              bitNext = '0;
            end else if (winCnt == WIN_LAST) begin
              ctrl.finUnknown = 1'b1;
            end else begin
              winNext = winCnt + WIN_W'(1);
            end
          end
          ST_CODE: begin
            ctrl.shiftCode = 1'b1;
            if (bitCnt == BIT_LAST) stNext = ST_ENDB;
            else bitNext = bitCnt + BIT_W'(1);
          end
          ST_ENDB: stNext = ST_BUSY;
          ST_BUSY: if (dat0) ctrl.finDecode = 1'b1;
          default: ;
        endcase
      end
      if (tmoHit && !ctrl.finUnknown && !ctrl.finDecode) ctrl.finTimeout = 1'b1;
      if (ctrl.finUnknown || ctrl.finDecode || ctrl.finTimeout) stNext = ST_IDLE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state  <= ST_IDLE;
      winCnt <= '0;
      bitCnt <= '0;
      tmoCnt <= '0;
    end else begin
      state  <= stNext;
      winCnt <= winNext;
      bitCnt <= bitNext;
      if (arm) tmoCnt <= '0;
      else if (state != ST_IDLE) tmoCnt <= tmoCnt + TMO_W'(1);
    end
  end

endmodule

// File: rtl/sdWrStatusDp.sv
module sdWrStatusDp
  import sdWrStatusPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  dpCtrl_t    ctrl,
  input  logic       dat0,
  output logic [1:0] status,
  output logic       done,
  output logic       abortXfer,
  output logic       timedOut
);

  logic [CODE_BITS-1:0] codeSr;
  wrStatus_e            outcome;

  assign outcome = decodeOutcome(codeSr);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      codeSr    <= '0;
      status    <= WS_UNKNOWN;
      done      <= 1'b0;
      abortXfer <= 1'b0;
      timedOut  <= 1'b0;
    end else begin
      done      <= 1'b0;
      abortXfer <= 1'b0;
      if (ctrl.armClr) timedOut <= 1'b0;
      if (ctrl.shiftCode) codeSr <= {codeSr[CODE_BITS-2:0], dat0};
      if (ctrl.finDecode) begin
        status    <= outcome;
        done      <= 1'b1;
        abortXfer <= (outcome != WS_ACCEPT);
      end
      if (ctrl.finUnknown || ctrl.finTimeout) begin
        status    <= WS_UNKNOWN;
        done      <= 1'b1;
        abortXfer <= 1'b1;
      end
      if (ctrl.finTimeout) timedOut <= 1'b1;
    end
  end

endmodule

// File: rtl/sdWrStatusRx.sv
module sdWrStatusRx
  import sdWrStatusPkg::*;
#(
  parameter int WIN_BITS = 32,
  parameter int TMO_W    = 28
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             arm,
  input  logic             sdClkEn,
  input  logic             dat0,
  input  logic [TMO_W-1:0] timeoutLimit,
  output logic             ready,
  output logic             done,
  output logic [1:0]       status,
  output logic             abortXfer,
  output logic             timedOut
);

  dpCtrl_t ctrl;

  sdWrStatusCtl #(.WIN_BITS(WIN_BITS), .TMO_W(TMO_W)) u_ctl (
    .clk(clk), .rstN(rstN), .arm(arm), .sdClkEn(sdClkEn), .dat0(dat0),
    .timeoutLimit(timeoutLimit), .ctrl(ctrl), .ready(ready)
  );

  sdWrStatusDp u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .dat0(dat0), .status(status),
    .done(done), .abortXfer(abortXfer), .timedOut(timedOut)
  );

endmodule

// File: rtl/sdWrStatusChk.sv
module sdWrStatusChk (
  input logic       clk,
  input logic       rstN,
  input logic       arm,
  input logic       ready,
  input logic       done,
  input logic [1:0] status,
  input logic       abortXfer,
  input logic       timedOut
);

  // R7: completion leaves the block idle
  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> ready);

  // R7: done lasts a single cycle
  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: abort only accompanies a completion
  assert_abort_with_done_R4: assert property (@(posedge clk) disable iff (!rstN)
    abortXfer |-> done);

  // R3: accepted outcome never aborts
  assert_accept_no_abort_R3: assert property (@(posedge clk) disable iff (!rstN)
    (done && status == 2'd0) |-> !abortXfer);

  // R9: timeout flag appears together with a completion
  assert_timeout_done_R9: assert property (@(posedge clk) disable iff (!rstN)
    $rose(timedOut) |-> (done && status == 2'd3));

  // R10: arm always starts an active search
  assert_arm_busy_R10: assert property (@(posedge clk) disable iff (!rstN)
    arm |=> (!ready && !timedOut));

endmodule

bind sdWrStatusRx sdWrStatusChk u_chk (
  .clk(clk), .rstN(rstN), .arm(arm), .ready(ready), .done(done),
  .status(status), .abortXfer(abortXfer), .timedOut(timedOut)
);

// File: tb/sim_sdWrStatusRx.sv
module sim_sdWrStatusRx;

  localparam int CLK_PERIOD = 10;
  localparam int WIN = 12;
  localparam int TW  = 10;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          arm = 1'b0;
  logic          sdClkEn = 1'b0;
  logic          dat0 = 1'b1;
  logic [TW-1:0] timeoutLimit = TW'(1000);
  logic          ready, done, abortXfer, timedOut;
  logic [1:0]    status;

  int vecCnt = 0;
  int errCnt = 0;
  string curReq = "R1";
  bit started = 0;
  bit finished = 0;

  // reference model state
  int mMode = 0;
  int mHi = 0, mBits = 0, mCode = 0, mTmo = 0;
  int eStatus = 3, eDone = 0, eAbort = 0, eTmo = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdWrStatusRx #(.WIN_BITS(WIN), .TMO_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .arm(arm), .sdClkEn(sdClkEn), .dat0(dat0),
    .timeoutLimit(timeoutLimit), .ready(ready), .done(done), .status(status),
    .abortXfer(abortXfer), .timedOut(timedOut)
  );

  function automatic int outcomeOf(int c);
    if (c == 2) return 0;
    if (c == 5) return 1;
    if (c == 6) return 2;
    return 3;
  endfunction

  always @(posedge clk) begin
    int fin;
    bit active;
    started = 1;
    eDone = 0;
    eAbort = 0;
    if (!rstN) begin
      mMode = 0; mTmo = 0; eStatus = 3; eTmo = 0;
    end else if (arm) begin
      mMode = 1; mHi = 0; mTmo = 0; eTmo = 0;
    end else if (mMode != 0) begin
      fin = -1;
      active = 1;
      if (sdClkEn) begin
        if (mMode == 1) begin
          if (dat0 == 1'b0) begin mMode = 2; mBits = 0; mCode = 0; end
          else if (mHi == WIN - 1) fin = 3;
          else mHi++;
        end else if (mMode == 2) begin
          mCode = (mCode * 2 + int'(dat0)) % 8;
          mBits++;
          if (mBits == 3) mMode = 3;
        end else if (mMode == 3) mMode = 4;
        else if (mMode == 4 && dat0) fin = outcomeOf(mCode);
      end
      if (fin < 0 && mTmo == int'(timeoutLimit)) begin fin = 3; eTmo = 1; end
      if (active) mTmo++;
      if (fin >= 0) begin
        eStatus = fin; eDone = 1; eAbort = (fin != 0); mMode = 0;
      end
    end
  end

  task automatic cmp(string nm, int act, int exp);
    vecCnt++;
    if (act != exp) begin
      errCnt++;
      $display("FAIL %s %s actual=%0d expected=%0d at %0t", curReq, nm, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (started && !finished) begin
      cmp("ready", int'(ready), (mMode == 0) ? 1 : 0);
      cmp("done", int'(done), eDone);
      cmp("status", int'(status), eStatus);
      cmp("abortXfer", int'(abortXfer), eAbort);
      cmp("timedOut", int'(timedOut), eTmo);
    end
  end

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic doArm();
    @(negedge clk) arm = 1'b1;
    @(negedge clk) arm = 1'b0;
  endtask

  task automatic sample(bit v, int gap);
    if (gap > 1) idle(gap - 1);
    @(negedge clk);
    dat0 = v; sdClkEn = 1'b1;
    @(negedge clk);
    sdClkEn = 1'b0; dat0 = 1'b1;
  endtask

  task automatic token(int lead, bit [2:0] code, int busyLen, int gap);
    doArm();
    for (int i = 0; i < lead; i++) sample(1'b1, gap);
    sample(1'b0, gap);
    for (int i = 2; i >= 0; i--) sample(code[i], gap);
    sample(1'b0, gap);                 // end bit value ignored (R7)
    for (int i = 0; i < busyLen; i++) sample(1'b0, gap);
    sample(1'b1, gap);
    idle(3);
  endtask

  initial begin
    curReq = "R1";
    idle(4);
    rstN = 1'b1;
    idle(2);
    curReq = "R3"; token(0, 3'b010, 0, 1);
    curReq = "R2"; token(5, 3'b010, 2, 3);
    curReq = "R4"; token(2, 3'b101, 1, 1);
    curReq = "R5"; token(1, 3'b110, 3, 2);
    curReq = "R6";
    token(0, 3'b000, 0, 1);
    token(0, 3'b111, 1, 1);
    token(3, 3'b011, 0, 2);
    token(0, 3'b001, 0, 1);
    token(0, 3'b100, 0, 1);
    curReq = "R7"; token(1, 3'b010, 20, 1);
    curReq = "R8";
    doArm();
    for (int i = 0; i < WIN + 3; i++) sample(1'b1, 2);
    idle(3);
    curReq = "R9";
    timeoutLimit = TW'(30);
    doArm(); idle(45);
    doArm();
    for (int i = 0; i < 4; i++) sample(1'b0, 1);
    for (int i = 0; i < 40; i++) sample(1'b0, 1);
    idle(3);
    timeoutLimit = TW'(6);
    doArm(); sample(1'b0, 1); sample(1'b1, 1); sample(1'b0, 1); idle(10);
    curReq = "R10";
    timeoutLimit = TW'(1000);
    doArm(); sample(1'b1, 1); sample(1'b0, 1); sample(1'b1, 1);
    token(0, 3'b101, 1, 1);
    timeoutLimit = TW'(8);
    doArm(); idle(15);
    timeoutLimit = TW'(1000);
    token(0, 3'b010, 0, 1);
    curReq = "R11";
    for (int i = 0; i < 6; i++) sample(i[0], 1);
    idle(4);
    finished = 1;
    if (!finishedByWd) begin
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  bit finishedByWd = 0;

  initial begin
    repeat (100000) @(posedge clk);
    finishedByWd = 1;
    finished = 1;
    errCnt++;
    $display("FAIL watchdog run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end

endmodule